// File: doc/BRIEF.md
# Banked Interrupt Line Controller

This block serves one bank of thirty-two level-sensitive interrupt lines and turns them into three requests: a normal CPU interrupt, a fast CPU interrupt, and a coprocessor interrupt. A line counts as pending when its input is high or when software has forced it. A pending line reaches the CPU only if its CPU enable bit is set. Its CPU class bit then sends it to the normal request (class 0) or to the fast request (class 1). The coprocessor has its own enable register, which takes the same pending lines and drives its own request.

Software uses a single-cycle register port with a 32-bit data path. The enable registers and the force register each have a direct-load address and two atomic aliases. Writing ones to the set alias sets bits. Writing ones to the clear alias clears bits. Zero bits leave the register unchanged, so one driver can change a single line without a read-modify-write. A system with more than thirty-two lines instantiates one bank per group of thirty-two: line n sits in bank n/32 at bit n%32.

Top module: `irq_line_bank`

## Requirements
- R1: After reset every enable, force and class bit is zero, all three requests are low, and any register reads back zero.
- R2: A write to offset 0x20 loads the whole CPU enable register. Ones written to 0x24 set the matching bits and ones written to 0x28 clear them. Zero bits in either alias change nothing, and the register does not change when no write targets it.
- R3: A single write of all ones to the CPU enable clear alias 0x28 disables every line of the bank.
- R4: The force register at 0x14 has a set alias at 0x18 and a clear alias at 0x1C. A forced line is pending exactly as if its input were high, and clearing the force leaves a line pending while its input stays high.
- R5: The CPU normal request is high exactly when some line is pending, CPU-enabled and has CPU class 0. A forced or asserted line whose CPU enable is clear has no effect.
- R6: The CPU fast request is high exactly when some line is pending, CPU-enabled and has CPU class 1.
- R7: The coprocessor request is high exactly when some line is pending and coprocessor-enabled. The coprocessor enable is at 0x30, with a set alias at 0x34 and a clear alias at 0x38.
- R8: A read of 0x08 returns one bit per line, set where that line is pending, CPU-enabled and of CPU class 1.
- R9: A read of a set or clear alias returns the current value of the register behind it.
- R10: Read data appears in the cycle after the read is accepted. A read of an unmapped offset, or of an address whose two low bits are not zero, returns zero. A write to such an address, or to 0x08, changes no register.
- R11: The CPU class register at 0x2C and the coprocessor class register at 0x3C store whatever is written to them and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Level interrupt inputs, one per line |
| reg_valid | input | 1 | Register access valid this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| cpu_irq | output | 1 | CPU normal interrupt request |
| cpu_fiq | output | 1 | CPU fast interrupt request |
| cop_irq | output | 1 | Coprocessor interrupt request |

## Verification
The overlap that needs care is a software write to the force clear alias in the same cycle as the hardware input of that line is held high. Because pending is the OR of both sources, the CPU request must stay asserted through the write. The bench raises the input, forces the line, then clears the force while the input is still high, and checks the request after the write takes effect. It also checks that a read of the fast-status word reflects the class write made just before it. Read results go through a queue of expected words, and the monitor compares each one in the cycle after the read.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Word indices (byte offset / 4) of the register map
  localparam int unsigned WI_VFIQ    = 2;   // 0x08
  localparam int unsigned WI_FRC     = 5;   // 0x14
  localparam int unsigned WI_FRC_SET = 6;   // 0x18
  localparam int unsigned WI_FRC_CLR = 7;   // 0x1C
  localparam int unsigned WI_CPU_EN  = 8;   // 0x20
  localparam int unsigned WI_CPU_SET = 9;   // 0x24
  localparam int unsigned WI_CPU_CLR = 10;  // 0x28
  localparam int unsigned WI_CPU_CLS = 11;  // 0x2C
  localparam int unsigned WI_COP_EN  = 12;  // 0x30
  localparam int unsigned WI_COP_SET = 13;  // 0x34
  localparam int unsigned WI_COP_CLR = 14;  // 0x38
  localparam int unsigned WI_COP_CLS = 15;  // 0x3C

  // Slots of the storage array
  localparam int unsigned RG_FRC     = 0;
  localparam int unsigned RG_CPU_EN  = 1;
  localparam int unsigned RG_CPU_CLS = 2;
  localparam int unsigned RG_COP_EN  = 3;
  localparam int unsigned RG_COP_CLS = 4;
  localparam int unsigned NUM_RG     = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } wsc_op_e;

endpackage

// File: rtl/irq_bank_wsc.sv
module irq_bank_wsc
  import irq_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wsc_op_e      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    q_d = q_r;
    upd = 1'b0;
    case (op)
      OP_LOAD: begin
        q_d = wdata;
        upd = 1'b1;
      end
      OP_SET: begin
        q_d = q_r | wdata;
        upd = 1'b1;
      end
      OP_CLR: begin
        q_d = q_r & ~wdata;
        upd = 1'b1;
      end
      default: begin
        q_d = q_r;
        upd = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       reg_valid,
  input  logic                       reg_write,
  input  logic [ADDR_W-1:0]          reg_addr,
  output wsc_op_e [NUM_RG-1:0]       ops
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_hit;

  assign idx    = reg_addr[ADDR_W-1:2];
  assign wr_hit = reg_valid & reg_write & (reg_addr[1:0] == 2'b00);

  always_comb begin
    for (int k = 0; k < NUM_RG; k++) begin
      ops[k] = OP_NONE;
    end
    if (wr_hit) begin
      case (idx)
        IDX_W'(WI_FRC):     ops[RG_FRC]     = OP_LOAD;
        IDX_W'(WI_FRC_SET): ops[RG_FRC]     = OP_SET;
        IDX_W'(WI_FRC_CLR): ops[RG_FRC]     = OP_CLR;
        IDX_W'(WI_CPU_EN):  ops[RG_CPU_EN]  = OP_LOAD;
        IDX_W'(WI_CPU_SET): ops[RG_CPU_EN]  = OP_SET;
        IDX_W'(WI_CPU_CLR): ops[RG_CPU_EN]  = OP_CLR;
        IDX_W'(WI_CPU_CLS): ops[RG_CPU_CLS] = OP_LOAD;
        IDX_W'(WI_COP_EN):  ops[RG_COP_EN]  = OP_LOAD;
        IDX_W'(WI_COP_SET): ops[RG_COP_EN]  = OP_SET;
        IDX_W'(WI_COP_CLR): ops[RG_COP_EN]  = OP_CLR;
        IDX_W'(WI_COP_CLS): ops[RG_COP_CLS] = OP_LOAD;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_bank_route.sv
module irq_bank_route #(
  parameter int LINES = 32
) (
  input  logic [LINES-1:0] src,
  input  logic [LINES-1:0] frc,
  input  logic [LINES-1:0] cpu_en,
  input  logic [LINES-1:0] cpu_cls,
  input  logic [LINES-1:0] cop_en,
  output logic [LINES-1:0] fiq_vec,
  output logic             cpu_irq,
  output logic             cpu_fiq,
  output logic             cop_irq
);

  logic [LINES-1:0] pend;
  logic [LINES-1:0] irq_vec;
  logic [LINES-1:0] cop_vec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      pend[i]    = src[i] | frc[i];
      irq_vec[i] = pend[i] & cpu_en[i] & ~cpu_cls[i];
      fiq_vec[i] = pend[i] & cpu_en[i] &  cpu_cls[i];
      cop_vec[i] = pend[i] & cop_en[i];
    end
  end

  assign cpu_irq = |irq_vec;
  assign cpu_fiq = |fiq_vec;
  assign cop_irq = |cop_vec;

endmodule

// File: rtl/irq_bank_rdport.sv
module irq_bank_rdport
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  frc,
  input  logic [LINES-1:0]  cpu_en,
  input  logic [LINES-1:0]  cpu_cls,
  input  logic [LINES-1:0]  cop_en,
  input  logic [LINES-1:0]  cop_cls,
  input  logic [LINES-1:0]  fiq_vec,
  output logic [LINES-1:0]  rdata
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             rd_upd;
  logic [LINES-1:0] rd_d;
  logic [LINES-1:0] rd_q;

  assign idx    = reg_addr[ADDR_W-1:2];
  assign rd_upd = reg_valid & ~reg_write;

  always_comb begin
    rd_d = '0;
    if (reg_addr[1:0] == 2'b00) begin
      case (idx)
        IDX_W'(WI_VFIQ):    rd_d = fiq_vec;
        IDX_W'(WI_FRC),
        IDX_W'(WI_FRC_SET),
        IDX_W'(WI_FRC_CLR): rd_d = frc;
        IDX_W'(WI_CPU_EN),
        IDX_W'(WI_CPU_SET),
        IDX_W'(WI_CPU_CLR): rd_d = cpu_en;
        IDX_W'(WI_CPU_CLS): rd_d = cpu_cls;
        IDX_W'(WI_COP_EN),
        IDX_W'(WI_COP_SET),
        IDX_W'(WI_COP_CLR): rd_d = cop_en;
        IDX_W'(WI_COP_CLS): rd_d = cop_cls;
        default:            rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_upd) begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_bank_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_src,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic              cpu_irq,
  output logic              cpu_fiq,
  output logic              cop_irq
);

  wsc_op_e [NUM_RG-1:0]            ops;
  logic [NUM_RG-1:0][LINES-1:0]    reg_q;
  logic [LINES-1:0]                frc_q;
  logic [LINES-1:0]                cpu_en_q;
  logic [LINES-1:0]                cpu_cls_q;
  logic [LINES-1:0]                cop_en_q;
  logic [LINES-1:0]                cop_cls_q;
  logic [LINES-1:0]                fiq_vec;

  irq_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .ops       (ops)
  );

  for (genvar g = 0; g < NUM_RG; g++) begin : g_reg
    irq_bank_wsc #(.W(LINES)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ops[g]),
      .wdata (reg_wdata),
      .q     (reg_q[g])
    );
  end

  assign frc_q     = reg_q[RG_FRC];
  assign cpu_en_q  = reg_q[RG_CPU_EN];
  assign cpu_cls_q = reg_q[RG_CPU_CLS];
  assign cop_en_q  = reg_q[RG_COP_EN];
  assign cop_cls_q = reg_q[RG_COP_CLS];

  irq_bank_route #(.LINES(LINES)) u_route (
    .src     (irq_src),
    .frc     (frc_q),
    .cpu_en  (cpu_en_q),
    .cpu_cls (cpu_cls_q),
    .cop_en  (cop_en_q),
    .fiq_vec (fiq_vec),
    .cpu_irq (cpu_irq),
    .cpu_fiq (cpu_fiq),
    .cop_irq (cop_irq)
  );

  irq_bank_rdport #(.ADDR_W(ADDR_W), .LINES(LINES)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .frc       (frc_q),
    .cpu_en    (cpu_en_q),
    .cpu_cls   (cpu_cls_q),
    .cop_en    (cop_en_q),
    .cop_cls   (cop_cls_q),
    .fiq_vec   (fiq_vec),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/irq_line_bank_chk.sv
module irq_line_bank_chk #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [LINES-1:0]  reg_wdata,
  input logic [LINES-1:0]  reg_rdata,
  input logic              cpu_irq,
  input logic              cpu_fiq,
  input logic              cop_irq,
  input logic [LINES-1:0]  frc_q,
  input logic [LINES-1:0]  cpu_en_q,
  input logic [LINES-1:0]  cpu_cls_q,
  input logic [LINES-1:0]  cop_en_q
);

  logic wr_go;
  logic rd_go;
  assign wr_go = reg_valid & reg_write;
  assign rd_go = reg_valid & ~reg_write;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_en_q == '0 && frc_q == '0 && cop_en_q == '0 && cpu_cls_q == '0));

  assert_cpu_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && reg_addr == ADDR_W'(8'h24)) |=> cpu_en_q == ($past(cpu_en_q) | $past(reg_wdata)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(cpu_en_q) && $stable(frc_q) && $stable(cop_en_q)));

  assert_cpu_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && reg_addr == ADDR_W'(8'h28)) |=> cpu_en_q == ($past(cpu_en_q) & ~$past(reg_wdata)));

  assert_frc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && reg_addr == ADDR_W'(8'h18)) |=> frc_q == ($past(frc_q) | $past(reg_wdata)));

  assert_frc_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && reg_addr == ADDR_W'(8'h1C)) |=> frc_q == ($past(frc_q) & ~$past(reg_wdata)));

  assert_cpu_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en_q == '0) |-> (!cpu_irq && !cpu_fiq));

  assert_all_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&cpu_cls_q) |-> !cpu_irq);

  assert_all_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_cls_q == '0) |-> !cpu_fiq);

  assert_cop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_en_q == '0) |-> !cop_irq);

  assert_unaligned_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && reg_addr[1:0] != 2'b00) |=> reg_rdata == '0);

endmodule

bind irq_line_bank irq_line_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cpu_irq   (cpu_irq),
  .cpu_fiq   (cpu_fiq),
  .cop_irq   (cop_irq),
  .frc_q     (frc_q),
  .cpu_en_q  (cpu_en_q),
  .cpu_cls_q (cpu_cls_q),
  .cop_en_q  (cop_en_q)
);

// File: tb/irq_line_bank_tb.sv
`timescale 1ns/1ps
module irq_line_bank_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] irq_src;
  logic        reg_valid;
  logic        reg_write;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  logic        cpu_fiq;
  logic        cop_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;
  bit rd_seen = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  irq_line_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq),
    .cpu_fiq   (cpu_fiq),
    .cop_irq   (cop_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor: pop expected read data one cycle after each accepted read
  always @(posedge clk) rd_seen <= reg_valid && !reg_write && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual=%08h expected=%08h", t, reg_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic chk_out(input logic ei, input logic ef, input logic ec, input string t);
    @(negedge clk);
    checks++;
    if (cpu_irq !== ei || cpu_fiq !== ef || cop_irq !== ec) begin
      errors++;
      $display("FAIL %s: irq/fiq/cop actual=%b%b%b expected=%b%b%b",
               t, cpu_irq, cpu_fiq, cop_irq, ei, ef, ec);
    end
  endtask

  initial begin
    rst_n = 1'b0; irq_src = '0; reg_valid = 1'b0; reg_write = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    irq_src = 32'hFFFF_FFFF;
    chk_out(0, 0, 0, "R1 outputs after reset");
    irq_src = '0;
    rd(8'h20, 32'h0, "R1 cpu enable after reset");
    rd(8'h14, 32'h0, "R1 force after reset");
    rd(8'h2C, 32'h0, "R1 class after reset");

    // R2 load, set alias, clear alias; R9 alias reads
    wr(8'h20, 32'h0000_00F0);
    rd(8'h20, 32'h0000_00F0, "R2 direct load");
    wr(8'h24, 32'h0000_0103);
    rd(8'h28, 32'h0000_01F3, "R2 set alias / R9 read via clear alias");
    wr(8'h28, 32'h0000_0011);
    rd(8'h24, 32'h0000_01E2, "R2 clear alias / R9 read via set alias");

    // R5 normal routing
    irq_src = 32'h2;
    chk_out(1, 0, 0, "R5 enabled class0 line");
    irq_src = 32'h1;
    chk_out(0, 0, 0, "R5 disabled line ignored");

    // R6 / R11 / R8 fast routing
    wr(8'h2C, 32'h2);
    irq_src = 32'h2;
    chk_out(0, 1, 0, "R6 class1 line to fast request");
    rd(8'h2C, 32'h2, "R11 cpu class readback");
    rd(8'h08, 32'h2, "R8 fast status word");

    // R7 coprocessor path
    wr(8'h34, 32'h1);
    irq_src = 32'h1;
    chk_out(0, 0, 1, "R7 coprocessor enabled line");
    rd(8'h30, 32'h1, "R7 coprocessor enable readback");
    rd(8'h34, 32'h1, "R9 coprocessor set alias read");
    wr(8'h38, 32'h1);
    chk_out(0, 0, 0, "R7 coprocessor clear alias");
    wr(8'h3C, 32'h5);
    rd(8'h3C, 32'h5, "R11 coprocessor class readback");

    // R4 force
    irq_src = '0;
    wr(8'h18, 32'h100);
    chk_out(1, 0, 0, "R4 forced line pending");
    rd(8'h14, 32'h100, "R4 force readback");
    rd(8'h1C, 32'h100, "R9 force clear alias read");
    wr(8'h1C, 32'h100);
    chk_out(0, 0, 0, "R4 force cleared");

    // R4 overlap: clear force while input is held high
    irq_src = 32'h100;
    wr(8'h18, 32'h100);
    wr(8'h1C, 32'h100);
    chk_out(1, 0, 0, "R4 input keeps line pending after force clear");
    rd(8'h14, 32'h0, "R4 force empty after clear");
    irq_src = '0;

    // R5 forced but disabled line has no effect
    wr(8'h14, 32'h1);
    chk_out(0, 0, 0, "R5 forced disabled line ignored");
    rd(8'h14, 32'h1, "R4 force direct load");
    wr(8'h14, 32'h0);

    // R3 clear everything in one access
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, 32'hFFFF_FFFF, "R2 set all");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R3 clear all in one write");
    irq_src = 32'hFFFF_FFFF;
    chk_out(0, 0, 0, "R3 no request after clear all");
    irq_src = '0;

    // R10 unmapped, unaligned, read-only
    rd(8'h00, 32'h0, "R10 unmapped 0x00");
    rd(8'h40, 32'h0, "R10 unmapped 0x40");
    rd(8'h21, 32'h0, "R10 unaligned read");
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h22, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R10 unmapped/unaligned writes ignored");
    rd(8'h14, 32'h0, "R10 force untouched");
    rd(8'h08, 32'h0, "R10 status write ignored");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule